// File: doc/BRIEF.md
# Boot Strap Latch and Code Alias Decoder

This block captures two boot strap pins a fixed number of system clock edges after reset is released, and again each time the chip returns from its standby state. The captured strap value picks a boot memory, which loads a two-bit remap mode. Software may later overwrite that mode. The mode decides which physical memory answers in the alias window at the bottom of the code address space. Flash, system memory, the first SRAM or the external memory bank can fill that window. Every one of these memories can also be reached at its own native address in every mode.

Each code-region access enters as an address with a valid bit. One clock later it leaves as a target code plus a translated physical address, or as an error response. Accesses are held off (`req_ready` low) until the straps have been captured. The second strap shares its pad with a general-purpose I/O. A release output hands that pad back once the strap has been captured.

Top module: `code_alias_ctrl`

## Requirements
- R1: After synchronous reset is released, the straps are captured on exactly the 4th rising clock edge (parameter `SAMPLE_EDGE`). `boot_done` and `req_ready` are low before that edge and high from that edge on.
- R2: A one-cycle `standby_exit` pulse clears `boot_done` on the edge where it is seen. The straps are then captured again on the 4th following edge.
- R3: When the straps are captured, `remap_q` loads from them as follows. If `strap_a`=0, the mode is 2'b00 (flash) and `strap_b` is ignored. If `strap_a`=1 and `strap_b`=0, the mode is 2'b01 (system memory). If both straps are 1, the mode is 2'b11 (SRAM).
- R4: `gpio_release` is low while capture is pending, and goes high on the same edge as the capture. It drops only on a standby exit.
- R5: A `remap_wr` write loads `remap_wdata` into `remap_q` on the next edge, but only once `boot_done` is high. Mode values are 00 flash, 01 system memory, 10 external memory and 11 SRAM. A write made while capture is pending leaves `remap_q` at the strap-derived mode.
- R6: No response is produced for a request made while `boot_done` is low.
- R7: A request accepted on an edge gives `rsp_valid` high after that same edge. In the flash, system memory and SRAM modes, an alias address A below the selected memory's size returns that memory's target and the address native base + A. Target codes are 1 flash, 2 system memory, 3 SRAM, 4 external region 1 and 5 external region 2. Native bases are 0x08000000 (512 KB), 0x1FFF0000 (30 KB) and 0x20000000 (112 KB).
- R8: An alias address below 0x00200000 that is at or beyond the selected memory's size returns `rsp_err`=1, target 0 and address 0. It is never wrapped.
- R9: In external mode, alias addresses 0x00000000-0x03FFFFFF map to target 4 and addresses 0x04000000-0x07FFFFFF map to target 5, both at 0x60000000 + A.
- R10: The native ranges of flash, system memory, SRAM and external memory (0x60000000-0x67FFFFFF, split into targets 4 and 5) decode to their own target with an unchanged address, in every mode.
- R11: Any other address, including 0x00200000-0x07FFFFFF outside external mode, returns an error with target 0 and address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_exit | input | 1 | One-cycle pulse when the chip leaves standby |
| strap_a | input | 1 | Dedicated boot strap pin |
| strap_b | input | 1 | Boot strap pin shared with a GPIO |
| gpio_release | output | 1 | High when the shared pad may return to GPIO use |
| boot_done | output | 1 | Straps have been captured |
| remap_wr | input | 1 | Write strobe for the remap mode |
| remap_wdata | input | 2 | New remap mode |
| remap_q | output | 2 | Current remap mode |
| req_valid | input | 1 | Code-region access request |
| req_addr | input | 32 | Request address |
| req_ready | output | 1 | Requests are accepted (low stalls) |
| rsp_valid | output | 1 | Response present |
| rsp_target | output | 3 | Selected physical target |
| rsp_addr | output | 32 | Translated physical address |
| rsp_err | output | 1 | Reserved or out-of-range access |

## Verification
Capture is checked edge by edge after reset and after a standby pulse: `boot_done`, `gpio_release` and `remap_q` must stay low or unchanged through the 3rd edge and switch on the 4th. A remap write takes effect on the edge that samples it and is read back one edge later. A response is due one edge after its request. The bench drives all inputs on the falling edge and reads every output on the next falling edge, so each result is checked half a period after the rising edge that produces it. The address sweep covers each size boundary of each memory in all four modes.

// File: rtl/code_alias_pkg.sv
package code_alias_pkg;

  typedef enum logic [1:0] {
    MODE_FLASH = 2'b00,
    MODE_SYS   = 2'b01,
    MODE_EXT   = 2'b10,
    MODE_SRAM  = 2'b11
  } remap_mode_e;

  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_FLASH = 3'd1,
    TGT_SYS   = 3'd2,
    TGT_SRAM  = 3'd3,
    TGT_EXT1  = 3'd4,
    TGT_EXT2  = 3'd5
  } target_e;

  // Strap pair to boot mode: primary strap low always means flash.
  function automatic remap_mode_e strap_to_mode(input logic s_a, input logic s_b);
    if (!s_a)     return MODE_FLASH;
    else if (!s_b) return MODE_SYS;
    else          return MODE_SRAM;
  endfunction

endpackage

// File: rtl/boot_strap_sampler.sv
module boot_strap_sampler #(
  parameter int SAMPLE_EDGE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic standby_exit,
  output logic capture,
  output logic done_q,
  output logic release_q
);
  localparam int CW = (SAMPLE_EDGE > 1) ? $clog2(SAMPLE_EDGE) : 1;
  localparam logic [CW-1:0] LAST = CW'(SAMPLE_EDGE - 1);

  logic [CW-1:0] edge_cnt;

  // Fires on the edge that is the SAMPLE_EDGE-th since reset/standby exit.
  assign capture = !standby_exit && !done_q && (edge_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_cnt  <= '0;
      done_q    <= 1'b0;
      release_q <= 1'b0;
    end else if (standby_exit) begin
      edge_cnt  <= '0;
      done_q    <= 1'b0;
      release_q <= 1'b0;
    end else if (!done_q) begin
      if (edge_cnt == LAST) begin
        done_q    <= 1'b1;
        release_q <= 1'b1;
      end else begin
        edge_cnt <= edge_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/remap_mode_reg.sv
module remap_mode_reg
  import code_alias_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        capture,
  input  logic        strap_a,
  input  logic        strap_b,
  input  logic        done,
  input  logic        standby_exit,
  input  logic        wr,
  input  logic [1:0]  wdata,
  output remap_mode_e mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_FLASH;
    end else if (capture) begin
      mode_q <= strap_to_mode(strap_a, strap_b);
    end else if (wr && done && !standby_exit) begin
      mode_q <= remap_mode_e'(wdata);
    end
  end
endmodule

// File: rtl/code_addr_decoder.sv
module code_addr_decoder
  import code_alias_pkg::*;
#(
  parameter int          AW              = 32,
  parameter logic [AW-1:0] FLASH_BASE    = 32'h0800_0000,
  parameter logic [AW-1:0] FLASH_BYTES   = 32'h0008_0000,
  parameter logic [AW-1:0] SYS_BASE      = 32'h1FFF_0000,
  parameter logic [AW-1:0] SYS_BYTES     = 32'h0000_7800,
  parameter logic [AW-1:0] SRAM_BASE     = 32'h2000_0000,
  parameter logic [AW-1:0] SRAM_BYTES    = 32'h0001_C000,
  parameter logic [AW-1:0] EXT_BASE      = 32'h6000_0000,
  parameter logic [AW-1:0] EXT_REGION    = 32'h0400_0000,
  parameter logic [AW-1:0] ALIAS_BYTES   = 32'h0020_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  remap_mode_e   mode,
  input  logic [AW-1:0] addr,
  output logic          rsp_valid,
  output target_e       rsp_target,
  output logic [AW-1:0] rsp_addr,
  output logic          rsp_err
);
  localparam logic [AW-1:0] EXT_SPAN = EXT_REGION << 1;

  target_e       nx_tgt;
  logic [AW-1:0] nx_addr;
  logic          nx_err;

  // Selected alias memory for the non-external modes.
  target_e       al_tgt;
  logic [AW-1:0] al_base;
  logic [AW-1:0] al_size;

  function automatic logic in_win(input logic [AW-1:0] a,
                                  input logic [AW-1:0] base,
                                  input logic [AW-1:0] size);
    return (a >= base) && ((a - base) < size);
  endfunction

  always_comb begin
    unique case (mode)
      MODE_SYS:  begin al_tgt = TGT_SYS;   al_base = SYS_BASE;   al_size = SYS_BYTES;   end
      MODE_SRAM: begin al_tgt = TGT_SRAM;  al_base = SRAM_BASE;  al_size = SRAM_BYTES;  end
      default:   begin al_tgt = TGT_FLASH; al_base = FLASH_BASE; al_size = FLASH_BYTES; end
    endcase
  end

  always_comb begin
    nx_tgt  = TGT_NONE;
    nx_addr = '0;
    nx_err  = 1'b1;
    if (in_win(addr, FLASH_BASE, FLASH_BYTES)) begin
      nx_tgt = TGT_FLASH; nx_addr = addr; nx_err = 1'b0;
    end else if (in_win(addr, SYS_BASE, SYS_BYTES)) begin
      nx_tgt = TGT_SYS; nx_addr = addr; nx_err = 1'b0;
    end else if (in_win(addr, SRAM_BASE, SRAM_BYTES)) begin
      nx_tgt = TGT_SRAM; nx_addr = addr; nx_err = 1'b0;
    end else if (in_win(addr, EXT_BASE, EXT_SPAN)) begin
      nx_tgt  = ((addr - EXT_BASE) < EXT_REGION) ? TGT_EXT1 : TGT_EXT2;
      nx_addr = addr;
      nx_err  = 1'b0;
    end else if (mode == MODE_EXT) begin
      if (addr < EXT_SPAN) begin
        nx_tgt  = (addr < EXT_REGION) ? TGT_EXT1 : TGT_EXT2;
        nx_addr = EXT_BASE + addr;
        nx_err  = 1'b0;
      end
    end else if (addr < ALIAS_BYTES && addr < al_size) begin
      nx_tgt  = al_tgt;
      nx_addr = al_base + addr;
      nx_err  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_target <= TGT_NONE;
      rsp_addr   <= '0;
      rsp_err    <= 1'b0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_target <= nx_tgt;
        rsp_addr   <= nx_addr;
        rsp_err    <= nx_err;
      end
    end
  end
endmodule

// File: rtl/code_alias_ctrl.sv
module code_alias_ctrl
  import code_alias_pkg::*;
#(
  parameter int SAMPLE_EDGE = 4,
  parameter int AW          = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          standby_exit,
  input  logic          strap_a,
  input  logic          strap_b,
  output logic          gpio_release,
  output logic          boot_done,
  input  logic          remap_wr,
  input  logic [1:0]    remap_wdata,
  output logic [1:0]    remap_q,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [2:0]    rsp_target,
  output logic [AW-1:0] rsp_addr,
  output logic          rsp_err
);
  logic        capture;
  remap_mode_e mode;
  target_e     tgt;

  boot_strap_sampler #(.SAMPLE_EDGE(SAMPLE_EDGE)) i_sampler (
    .clk          (clk),
    .rst          (rst),
    .standby_exit (standby_exit),
    .capture      (capture),
    .done_q       (boot_done),
    .release_q    (gpio_release)
  );

  remap_mode_reg i_mode (
    .clk          (clk),
    .rst          (rst),
    .capture      (capture),
    .strap_a      (strap_a),
    .strap_b      (strap_b),
    .done         (boot_done),
    .standby_exit (standby_exit),
    .wr           (remap_wr),
    .wdata        (remap_wdata),
    .mode_q       (mode)
  );

  code_addr_decoder #(.AW(AW)) i_dec (
    .clk        (clk),
    .rst        (rst),
    .accept     (req_valid && boot_done),
    .mode       (mode),
    .addr       (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_target (tgt),
    .rsp_addr   (rsp_addr),
    .rsp_err    (rsp_err)
  );

  assign remap_q    = mode;
  assign rsp_target = tgt;
  assign req_ready  = boot_done;
endmodule

// File: rtl/code_alias_ctrl_chk.sv
module code_alias_ctrl_chk #(
  parameter int SAMPLE_EDGE = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       standby_exit,
  input logic       boot_done,
  input logic       gpio_release,
  input logic       remap_wr,
  input logic [1:0] remap_q,
  input logic       req_valid,
  input logic       rsp_valid,
  input logic       rsp_err,
  input logic [2:0] rsp_target
);
  logic [15:0] since_start;

  always_ff @(posedge clk) begin
    if (rst || standby_exit) since_start <= '0;
    else if (!boot_done && since_start != 16'hFFFF) since_start <= since_start + 1'b1;
  end

  AST_CAPTURE_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(boot_done) |-> (since_start == 16'(SAMPLE_EDGE)));                 // R1
  AST_STANDBY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    standby_exit |=> !boot_done);                                            // R2
  AST_RELEASE_DROP: assert property (@(posedge clk) disable iff (rst)
    $fell(gpio_release) |-> $past(standby_exit));                            // R4
  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (boot_done && !remap_wr) |=> $stable(remap_q));                          // R5
  AST_NO_EARLY_RSP: assert property (@(posedge clk) disable iff (rst)
    !boot_done |=> !rsp_valid);                                              // R6
  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && boot_done) |=> rsp_valid);                                 // R7
  AST_ERR_NO_TARGET: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_target == 3'd0));                        // R8
endmodule

bind code_alias_ctrl code_alias_ctrl_chk #(.SAMPLE_EDGE(SAMPLE_EDGE)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .standby_exit (standby_exit),
  .boot_done    (boot_done),
  .gpio_release (gpio_release),
  .remap_wr     (remap_wr),
  .remap_q      (remap_q),
  .req_valid    (req_valid),
  .rsp_valid    (rsp_valid),
  .rsp_err      (rsp_err),
  .rsp_target   (rsp_target)
);

// File: tb/test_code_alias_ctrl.sv
module test_code_alias_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        standby_exit = 1'b0;
  logic        strap_a = 1'b0;
  logic        strap_b = 1'b0;
  logic        gpio_release, boot_done, req_ready;
  logic        remap_wr = 1'b0;
  logic [1:0]  remap_wdata = 2'b00;
  logic [1:0]  remap_q;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_err;
  logic [2:0]  rsp_target;
  logic [31:0] rsp_addr;

  int checks = 0;
  int errors = 0;

  logic [2:0]  e_tgt;
  logic [31:0] e_addr;
  logic        e_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  code_alias_ctrl i_code_alias_ctrl (
    .clk(clk), .rst(rst), .standby_exit(standby_exit),
    .strap_a(strap_a), .strap_b(strap_b),
    .gpio_release(gpio_release), .boot_done(boot_done),
    .remap_wr(remap_wr), .remap_wdata(remap_wdata), .remap_q(remap_q),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_target(rsp_target), .rsp_addr(rsp_addr),
    .rsp_err(rsp_err)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] mode_of(input logic a, input logic b);
    if (!a) return 2'b00;
    if (!b) return 2'b01;
    return 2'b11;
  endfunction

  function automatic logic [31:0] sweep_addr(input int i);
    case (i)
      0:  return 32'h0000_0000;  1:  return 32'h0000_0004;
      2:  return 32'h0000_77FC;  3:  return 32'h0000_7800;
      4:  return 32'h0001_BFFC;  5:  return 32'h0001_C000;
      6:  return 32'h0007_FFFC;  7:  return 32'h0008_0000;
      8:  return 32'h001F_FFFC;  9:  return 32'h0020_0000;
      10: return 32'h03FF_FFFC;  11: return 32'h0400_0000;
      12: return 32'h07FF_FFFC;  13: return 32'h0800_0000;
      14: return 32'h0807_FFFC;  15: return 32'h0808_0000;
      16: return 32'h1FFF_0000;  17: return 32'h1FFF_77FC;
      18: return 32'h1FFF_7800;  19: return 32'h2000_0000;
      20: return 32'h2001_BFFC;  21: return 32'h2001_C000;
      22: return 32'h6000_0000;  23: return 32'h67FF_FFFC;
      24: return 32'h6800_0000;  default: return 32'h4000_0000;
    endcase
  endfunction

  // Expected decode from R7-R11.
  task automatic model(input logic [1:0] m, input logic [31:0] a);
    logic [31:0] sz, bs;
    logic [2:0]  t;
    e_tgt = 3'd0; e_addr = 32'd0; e_err = 1'b1;
    if (a >= 32'h0800_0000 && a < 32'h0808_0000) begin e_tgt = 3'd1; e_addr = a; e_err = 1'b0; end
    else if (a >= 32'h1FFF_0000 && a < 32'h1FFF_7800) begin e_tgt = 3'd2; e_addr = a; e_err = 1'b0; end
    else if (a >= 32'h2000_0000 && a < 32'h2001_C000) begin e_tgt = 3'd3; e_addr = a; e_err = 1'b0; end
    else if (a >= 32'h6000_0000 && a < 32'h6800_0000) begin
      e_tgt = (a < 32'h6400_0000) ? 3'd4 : 3'd5; e_addr = a; e_err = 1'b0;
    end else if (m == 2'b10) begin
      if (a < 32'h0800_0000) begin
        e_tgt = (a < 32'h0400_0000) ? 3'd4 : 3'd5; e_addr = 32'h6000_0000 + a; e_err = 1'b0;
      end
    end else begin
      case (m)
        2'b01:   begin sz = 32'h7800;  bs = 32'h1FFF_0000; t = 3'd2; end
        2'b11:   begin sz = 32'h1C000; bs = 32'h2000_0000; t = 3'd3; end
        default: begin sz = 32'h80000; bs = 32'h0800_0000; t = 3'd1; end
      endcase
      if (a < 32'h0020_0000 && a < sz) begin e_tgt = t; e_addr = bs + a; e_err = 1'b0; end
    end
  endtask

  // Reset, then watch each edge up to the capture edge (R1, R3, R4, R5, R6).
  task automatic reset_and_capture(input logic a, input logic b);
    @(negedge clk);
    rst = 1'b1; strap_a = a; strap_b = b;
    repeat (3) @(negedge clk);
    check("R1 reset boot_done", boot_done, 0);
    check("R4 reset release", gpio_release, 0);
    rst = 1'b0;
    req_valid = 1'b1; req_addr = 32'h0;
    remap_wr = 1'b1; remap_wdata = 2'b10;
    for (int e = 1; e <= 4; e++) begin
      @(negedge clk);
      check("R1 boot_done per edge", boot_done, (e >= 4));
      check("R1 req_ready per edge", req_ready, (e >= 4));
      check("R4 release per edge", gpio_release, (e >= 4));
      check("R6 no early response", rsp_valid, 0);
    end
    req_valid = 1'b0; remap_wr = 1'b0;
    check("R3 R5 strap mode, early write ignored", remap_q, mode_of(a, b));
  endtask

  task automatic write_mode(input logic [1:0] m);
    @(negedge clk);
    remap_wr = 1'b1; remap_wdata = m;
    @(negedge clk);
    remap_wr = 1'b0;
    check("R5 remap write", remap_q, m);
  endtask

  task automatic access(input logic [1:0] m, input logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    model(m, a);
    check("R7 response valid", rsp_valid, 1);
    if (a < 32'h0800_0000 && !(m == 2'b10) && a >= 32'h0020_0000)
      check("R11 reserved low range", {rsp_err, rsp_target, rsp_addr}, {e_err, e_tgt, e_addr});
    else if (a < 32'h0800_0000 && m == 2'b10)
      check("R9 external alias", {rsp_err, rsp_target, rsp_addr}, {e_err, e_tgt, e_addr});
    else if (a < 32'h0020_0000)
      check("R7 R8 alias decode", {rsp_err, rsp_target, rsp_addr}, {e_err, e_tgt, e_addr});
    else
      check("R10 R11 native decode", {rsp_err, rsp_target, rsp_addr}, {e_err, e_tgt, e_addr});
  endtask

  initial begin
    for (int p = 0; p < 4; p++) reset_and_capture(p[0], p[1]);

    // Standby exit resamples with new straps (R2, R3, R4).
    reset_and_capture(1'b0, 1'b1);
    @(negedge clk);
    strap_a = 1'b1; strap_b = 1'b1; standby_exit = 1'b1;
    @(negedge clk);
    standby_exit = 1'b0;
    check("R2 standby clears done", boot_done, 0);
    check("R4 standby withdraws release", gpio_release, 0);
    for (int e = 1; e <= 4; e++) begin
      @(negedge clk);
      check("R2 resample edge", boot_done, (e >= 4));
    end
    check("R3 resampled mode", remap_q, 2'b11);

    // Request while stalled gets no response (R6).
    @(negedge clk);
    standby_exit = 1'b1;
    @(negedge clk);
    standby_exit = 1'b0; req_valid = 1'b1; req_addr = 32'h0800_0000;
    @(negedge clk);
    req_valid = 1'b0;
    check("R6 stalled request", rsp_valid, 0);
    repeat (4) @(negedge clk);

    // Decode sweep over all modes (R7-R11).
    for (int m = 0; m < 4; m++) begin
      write_mode(m[1:0]);
      for (int i = 0; i < 26; i++) access(m[1:0], sweep_addr(i));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule